// File: doc/BRIEF.md
# Link-to-System-Bus Write Merge and Error Mapper

This block sits on the inbound path of an I/O bridge. It takes one link request at a time (a read, a posted write or a non-posted write) that targets internal space and turns it into one or two system-bus commands. From the request it works out three command attributes. The first is coherency, set when the address falls in the memory range. The second is L2 allocation, set when the request carries the isochronous flag. The third is the byte-lane endian policy, chosen by one address bit when the system is big-endian.

A coherent write that covers less than the full 32-byte line cannot go straight to memory. The block first issues a read-exclusive to get the line and its ownership. It then overlays the new bytes under the 32-bit byte mask and writes the complete line back. A coherent write with every byte enabled skips the read. When a read returns, a master-abort mode bit decides how the system-bus error code is reported on the link.

Top module: `lsb_bridge`

## Requirements
- R1: `sb_cmd_lane` is 1 (match-bit policy) exactly when `cfg_big_endian` is 1 and request address bit LANE_SEL_BIT (39) is 1. Otherwise it is 0 (match-byte policy). `sb_cmd_addr` is the request address with that bit and the five line-offset bits cleared.
- R2: Every command issued for a request has `sb_cmd_l2alloc` equal to the request's `req_isoc`.
- R3: An address is in the memory range when its value, with the lane bit cleared, is below MEM_LIMIT (0x80000000). Such an address gives `sb_cmd_coherent`=1, and its reads use `sb_cmd_be` all ones. Any other address gives `sb_cmd_coherent`=0 and a single command (op 0 = read, op 2 = write) whose `sb_cmd_be` equals `req_be`.
- R4: A coherent write whose `req_be` is not all ones issues op 1 (read-exclusive) with all byte enables set. After the line returns, it issues op 2 with all byte enables set. In that write's data, byte i comes from `req_data` where `req_be[i]` is 1 and from the returned line otherwise.
- R5: A coherent write with `req_be` all ones issues one op 2 command carrying `req_data` and no read-exclusive.
- R6: With `cfg_mabort_mode`=1, a read returning any nonzero `sb_rsp_err` (1 bus, 2 fatal, 3 other) gives `lk_rsp_err`=1 and `lk_rsp_nxa`=0.
- R7: With `cfg_mabort_mode`=0, error codes 1 and 2 give `lk_rsp_err`=0 with the returned data. Code 3 gives `lk_rsp_err`=1 and `lk_rsp_nxa`=0.
- R8: A non-posted write gives exactly one link response with `lk_rsp_err`=0, even when its read-exclusive returned an error. A posted write gives no link response.
- R9: `req_ready` is low from the cycle after acceptance until the request's final cycle. A command held with `sb_cmd_ready` low keeps its op and address.
- R10: A read answered with code 0 returns the line on `lk_rsp_data` with `lk_rsp_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_big_endian | input | 1 | System is big-endian |
| cfg_mabort_mode | input | 1 | Master-abort error mapping mode |
| req_valid | input | 1 | Link request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | Request is a write |
| req_posted | input | 1 | Write is posted (no response) |
| req_isoc | input | 1 | Isochronous flag |
| req_addr | input | 40 | Request address |
| req_be | input | 32 | Byte mask within the line |
| req_data | input | 256 | Write data, one full line |
| sb_cmd_valid | output | 1 | System-bus command valid |
| sb_cmd_ready | input | 1 | System bus takes the command |
| sb_cmd_op | output | 2 | 0 read, 1 read-exclusive, 2 write |
| sb_cmd_addr | output | 40 | Line-aligned address, lane bit cleared |
| sb_cmd_coherent | output | 1 | Cacheable coherent access |
| sb_cmd_l2alloc | output | 1 | Allocate in L2 |
| sb_cmd_lane | output | 1 | 1 match-bit, 0 match-byte lanes |
| sb_cmd_be | output | 32 | Byte enables |
| sb_cmd_data | output | 256 | Write data |
| sb_rsp_valid | input | 1 | Read data return |
| sb_rsp_err | input | 2 | 0 ok, 1 bus, 2 fatal, 3 other |
| sb_rsp_data | input | 256 | Returned line |
| lk_rsp_valid | output | 1 | Link response, one cycle |
| lk_rsp_err | output | 1 | Link error response |
| lk_rsp_nxa | output | 1 | Non-existent-address flag |
| lk_rsp_data | output | 256 | Read data |

## Verification
The assertions take for granted that `sb_rsp_valid` is pulsed once for each read or read-exclusive command, and only after that command is taken. They also assume the two configuration bits stay still while a request is in flight. The bench memory responder answers only read-type commands, with a fixed two-cycle delay. The configuration bits are changed only between requests, while `req_ready` is high.

// File: rtl/lsb_pkg.sv
package lsb_pkg;
  localparam logic [1:0] OP_RD   = 2'd0;
  localparam logic [1:0] OP_RDEX = 2'd1;
  localparam logic [1:0] OP_WR   = 2'd2;

  localparam logic [1:0] SBE_OK    = 2'd0;
  localparam logic [1:0] SBE_BUS   = 2'd1;
  localparam logic [1:0] SBE_FATAL = 2'd2;
  localparam logic [1:0] SBE_OTHER = 2'd3;

  typedef enum logic [2:0] {
    S_IDLE, S_ISSUE, S_RD_EXCL, S_WAIT_DATA, S_MERGE, S_WRITEBACK, S_DONE
  } seq_state_e;

  typedef struct packed {
    logic err;
    logic nxa;
  } lk_status_t;

  // Map a system-bus read status onto a link status.
  function automatic lk_status_t map_sb_error(input logic [1:0] code,
                                              input logic abort_mode);
    lk_status_t s;
    s.nxa = 1'b0;
    if (code == SBE_OK)      s.err = 1'b0;
    else if (abort_mode)     s.err = 1'b1;
    else                     s.err = (code == SBE_OTHER);
    return s;
  endfunction
endpackage

// File: rtl/lsb_attr_decode.sv
module lsb_attr_decode #(
  parameter int AW           = 40,
  parameter int LINE_BYTES   = 32,
  parameter int LANE_SEL_BIT = 39,
  parameter logic [AW-1:0] MEM_LIMIT = 40'h00_8000_0000
) (
  input  logic [AW-1:0]         in_addr,
  input  logic [LINE_BYTES-1:0] in_be,
  input  logic                  in_isoc,
  input  logic                  big_endian,
  output logic [AW-1:0]         out_addr,
  output logic                  out_coherent,
  output logic                  out_l2alloc,
  output logic                  out_lane,
  output logic                  out_full
);
  localparam int OFS = $clog2(LINE_BYTES);

  function automatic logic [AW-1:0] drop_lane(input logic [AW-1:0] a);
    logic [AW-1:0] t;
    t = a;
    t[LANE_SEL_BIT] = 1'b0;
    return t;
  endfunction

  function automatic logic [AW-1:0] line_base(input logic [AW-1:0] a);
    logic [AW-1:0] t;
    t = drop_lane(a);
    t[OFS-1:0] = '0;
    return t;
  endfunction

  function automatic logic in_mem_range(input logic [AW-1:0] a);
    return drop_lane(a) < MEM_LIMIT;
  endfunction

  assign out_addr     = line_base(in_addr);
  assign out_coherent = in_mem_range(in_addr);
  assign out_l2alloc  = in_isoc;
  assign out_lane     = big_endian & in_addr[LANE_SEL_BIT];
  assign out_full     = &in_be;
endmodule

// File: rtl/lsb_err_map.sv
module lsb_err_map
  import lsb_pkg::*;
(
  input  logic [1:0] code,
  input  logic       abort_mode,
  output logic       err,
  output logic       nxa
);
  lk_status_t st;
  assign st  = map_sb_error(code, abort_mode);
  assign err = st.err;
  assign nxa = st.nxa;
endmodule

// File: rtl/lsb_line_merge.sv
module lsb_line_merge #(
  parameter int LINE_BYTES = 32
) (
  input  logic [LINE_BYTES*8-1:0] old_line,
  input  logic [LINE_BYTES*8-1:0] new_line,
  input  logic [LINE_BYTES-1:0]   be,
  output logic [LINE_BYTES*8-1:0] merged
);
  for (genvar i = 0; i < LINE_BYTES; i++) begin : g_byte
    assign merged[i*8 +: 8] = be[i] ? new_line[i*8 +: 8] : old_line[i*8 +: 8];
  end
endmodule

// File: rtl/lsb_seq.sv
module lsb_seq
  import lsb_pkg::*;
#(
  parameter int AW         = 40,
  parameter int LINE_BYTES = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_mabort_mode,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic                    req_posted,
  input  logic [LINE_BYTES-1:0]   req_be,
  input  logic [LINE_BYTES*8-1:0] req_data,
  input  logic [AW-1:0]           d_addr,
  input  logic                    d_coherent,
  input  logic                    d_l2alloc,
  input  logic                    d_lane,
  input  logic                    d_full,
  output logic                    sb_cmd_valid,
  input  logic                    sb_cmd_ready,
  output logic [1:0]              sb_cmd_op,
  output logic [AW-1:0]           sb_cmd_addr,
  output logic                    sb_cmd_coherent,
  output logic                    sb_cmd_l2alloc,
  output logic                    sb_cmd_lane,
  output logic [LINE_BYTES-1:0]   sb_cmd_be,
  output logic [LINE_BYTES*8-1:0] sb_cmd_data,
  input  logic                    sb_rsp_valid,
  input  logic [1:0]              sb_rsp_err,
  input  logic [LINE_BYTES*8-1:0] sb_rsp_data,
  output logic                    lk_rsp_valid,
  output logic                    lk_rsp_err,
  output logic                    lk_rsp_nxa,
  output logic [LINE_BYTES*8-1:0] lk_rsp_data
);
  localparam int LINE_BITS = LINE_BYTES * 8;
  localparam logic [LINE_BYTES-1:0] ALL_BE = '1;

  seq_state_e state, state_n;

  logic [AW-1:0]         r_addr;
  logic                  r_coh, r_l2, r_lane, r_write, r_posted;
  logic [LINE_BYTES-1:0] r_be;
  logic [LINE_BITS-1:0]  r_data, r_line;
  logic                  r_err, r_nxa;

  // Named internal events
  logic ev_accept, ev_cmd_fire, ev_rsp_take, ev_need_merge;
  assign ev_accept     = req_valid && req_ready;
  assign ev_cmd_fire   = sb_cmd_valid && sb_cmd_ready;
  assign ev_rsp_take   = (state == S_WAIT_DATA) && sb_rsp_valid;
  assign ev_need_merge = req_write && d_coherent && !d_full;

  logic m_err, m_nxa;
  lsb_err_map u_emap (
    .code(sb_rsp_err), .abort_mode(cfg_mabort_mode), .err(m_err), .nxa(m_nxa)
  );

  logic [LINE_BITS-1:0] merged;
  lsb_line_merge #(.LINE_BYTES(LINE_BYTES)) u_merge (
    .old_line(r_line), .new_line(r_data), .be(r_be), .merged(merged)
  );

  always_comb begin
    state_n = state;
    unique case (state)
      S_IDLE:      if (req_valid) state_n = ev_need_merge ? S_RD_EXCL : S_ISSUE;
      S_ISSUE:     if (sb_cmd_ready) state_n = r_write ? S_DONE : S_WAIT_DATA;
      S_RD_EXCL:   if (sb_cmd_ready) state_n = S_WAIT_DATA;
      S_WAIT_DATA: if (sb_rsp_valid) state_n = r_write ? S_MERGE : S_DONE;
      S_MERGE:     state_n = S_WRITEBACK;
      S_WRITEBACK: if (sb_cmd_ready) state_n = S_DONE;
      S_DONE:      state_n = S_IDLE;
      default:     state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      r_addr   <= '0;
      r_coh    <= 1'b0;
      r_l2     <= 1'b0;
      r_lane   <= 1'b0;
      r_write  <= 1'b0;
      r_posted <= 1'b0;
      r_be     <= '0;
      r_data   <= '0;
      r_line   <= '0;
      r_err    <= 1'b0;
      r_nxa    <= 1'b0;
    end else begin
      state <= state_n;
      if (ev_accept) begin
        r_addr   <= d_addr;
        r_coh    <= d_coherent;
        r_l2     <= d_l2alloc;
        r_lane   <= d_lane;
        r_write  <= req_write;
        r_posted <= req_posted;
        r_be     <= req_be;
        r_data   <= req_data;
        r_err    <= 1'b0;
        r_nxa    <= 1'b0;
      end
      if (ev_rsp_take) begin
        r_line <= sb_rsp_data;
        // writes are posted internally: their read status is dropped
        r_err  <= r_write ? 1'b0 : m_err;
        r_nxa  <= r_write ? 1'b0 : m_nxa;
      end
      if (state == S_MERGE) r_line <= merged;
    end
  end

  assign req_ready = (state == S_IDLE);

  always_comb begin
    sb_cmd_valid = 1'b0;
    sb_cmd_op    = OP_RD;
    sb_cmd_be    = ALL_BE;
    sb_cmd_data  = r_data;
    unique case (state)
      S_ISSUE: begin
        sb_cmd_valid = 1'b1;
        sb_cmd_op    = r_write ? OP_WR : OP_RD;
        sb_cmd_be    = (r_coh && !r_write) ? ALL_BE : r_be;
      end
      S_RD_EXCL: begin
        sb_cmd_valid = 1'b1;
        sb_cmd_op    = OP_RDEX;
      end
      S_WRITEBACK: begin
        sb_cmd_valid = 1'b1;
        sb_cmd_op    = OP_WR;
        sb_cmd_data  = r_line;
      end
      default: ;
    endcase
  end

  assign sb_cmd_addr     = r_addr;
  assign sb_cmd_coherent = r_coh;
  assign sb_cmd_l2alloc  = r_l2;
  assign sb_cmd_lane     = r_lane;

  assign lk_rsp_valid = (state == S_DONE) && !(r_write && r_posted);
  assign lk_rsp_err   = r_err;
  assign lk_rsp_nxa   = r_nxa;
  assign lk_rsp_data  = r_write ? '0 : r_line;

  // R9: busy after acceptance, command held while stalled
  p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> !req_ready);
  p_cmd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sb_cmd_valid && !sb_cmd_ready |=>
      sb_cmd_valid && $stable(sb_cmd_op) && $stable(sb_cmd_addr));
  // R4: after the merge step a full-line write follows
  p_wb_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_MERGE) |=> sb_cmd_valid && (sb_cmd_op == OP_WR) && (&sb_cmd_be));
  // R8: write completions never carry an error
  p_wr_noerr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lk_rsp_valid && r_write |-> !lk_rsp_err);
  // R6: abort mode turns every read error into a link error
  p_mabort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rsp_take && !r_write && cfg_mabort_mode && (sb_rsp_err != SBE_OK)
      |=> lk_rsp_valid && lk_rsp_err && !lk_rsp_nxa);
endmodule

// File: rtl/lsb_bridge.sv
module lsb_bridge
  import lsb_pkg::*;
#(
  parameter int AW           = 40,
  parameter int LINE_BYTES   = 32,
  parameter int LANE_SEL_BIT = 39,
  parameter logic [AW-1:0] MEM_LIMIT = 40'h00_8000_0000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_big_endian,
  input  logic                    cfg_mabort_mode,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic                    req_posted,
  input  logic                    req_isoc,
  input  logic [AW-1:0]           req_addr,
  input  logic [LINE_BYTES-1:0]   req_be,
  input  logic [LINE_BYTES*8-1:0] req_data,
  output logic                    sb_cmd_valid,
  input  logic                    sb_cmd_ready,
  output logic [1:0]              sb_cmd_op,
  output logic [AW-1:0]           sb_cmd_addr,
  output logic                    sb_cmd_coherent,
  output logic                    sb_cmd_l2alloc,
  output logic                    sb_cmd_lane,
  output logic [LINE_BYTES-1:0]   sb_cmd_be,
  output logic [LINE_BYTES*8-1:0] sb_cmd_data,
  input  logic                    sb_rsp_valid,
  input  logic [1:0]              sb_rsp_err,
  input  logic [LINE_BYTES*8-1:0] sb_rsp_data,
  output logic                    lk_rsp_valid,
  output logic                    lk_rsp_err,
  output logic                    lk_rsp_nxa,
  output logic [LINE_BYTES*8-1:0] lk_rsp_data
);
  logic [AW-1:0] d_addr;
  logic          d_coherent, d_l2alloc, d_lane, d_full;

  lsb_attr_decode #(
    .AW(AW), .LINE_BYTES(LINE_BYTES), .LANE_SEL_BIT(LANE_SEL_BIT), .MEM_LIMIT(MEM_LIMIT)
  ) u_dec (
    .in_addr(req_addr), .in_be(req_be), .in_isoc(req_isoc), .big_endian(cfg_big_endian),
    .out_addr(d_addr), .out_coherent(d_coherent), .out_l2alloc(d_l2alloc),
    .out_lane(d_lane), .out_full(d_full)
  );

  lsb_seq #(.AW(AW), .LINE_BYTES(LINE_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_n), .cfg_mabort_mode(cfg_mabort_mode),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_posted(req_posted), .req_be(req_be), .req_data(req_data),
    .d_addr(d_addr), .d_coherent(d_coherent), .d_l2alloc(d_l2alloc),
    .d_lane(d_lane), .d_full(d_full),
    .sb_cmd_valid(sb_cmd_valid), .sb_cmd_ready(sb_cmd_ready), .sb_cmd_op(sb_cmd_op),
    .sb_cmd_addr(sb_cmd_addr), .sb_cmd_coherent(sb_cmd_coherent),
    .sb_cmd_l2alloc(sb_cmd_l2alloc), .sb_cmd_lane(sb_cmd_lane),
    .sb_cmd_be(sb_cmd_be), .sb_cmd_data(sb_cmd_data),
    .sb_rsp_valid(sb_rsp_valid), .sb_rsp_err(sb_rsp_err), .sb_rsp_data(sb_rsp_data),
    .lk_rsp_valid(lk_rsp_valid), .lk_rsp_err(lk_rsp_err), .lk_rsp_nxa(lk_rsp_nxa),
    .lk_rsp_data(lk_rsp_data)
  );

  // R4/R3: read-exclusive is always a coherent full-line command
  p_rdex_coh_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sb_cmd_valid && (sb_cmd_op == OP_RDEX) |-> sb_cmd_coherent && (&sb_cmd_be));
  // R1: issued addresses are line aligned with the lane bit removed
  p_addr_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sb_cmd_valid |-> !sb_cmd_addr[LANE_SEL_BIT] && (sb_cmd_addr[$clog2(LINE_BYTES)-1:0] == '0));
endmodule

// File: tb/sim_lsb_bridge.sv
`timescale 1ns/1ps
module sim_lsb_bridge;
  localparam int AW = 40;
  localparam int NB = 32;
  localparam int LB = NB * 8;
  localparam logic [AW-1:0] LANE_M = 40'h80_0000_0000;
  localparam logic [AW-1:0] MEM_A  = 40'h00_0000_1000;
  localparam logic [AW-1:0] IO_A   = 40'h00_9000_0000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          cfg_big_endian = 1'b0, cfg_mabort_mode = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0, req_posted = 1'b0, req_isoc = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [NB-1:0] req_be = '0;
  logic [LB-1:0] req_data = '0;
  logic          req_ready;
  logic          sb_cmd_valid, sb_cmd_coherent, sb_cmd_l2alloc, sb_cmd_lane;
  logic          sb_cmd_ready = 1'b1;
  logic [1:0]    sb_cmd_op;
  logic [AW-1:0] sb_cmd_addr;
  logic [NB-1:0] sb_cmd_be;
  logic [LB-1:0] sb_cmd_data;
  logic          sb_rsp_valid = 1'b0;
  logic [1:0]    sb_rsp_err = 2'd0;
  logic [LB-1:0] sb_rsp_data = '0;
  logic          lk_rsp_valid, lk_rsp_err, lk_rsp_nxa;
  logic [LB-1:0] lk_rsp_data;

  lsb_bridge u0 (.*);

  int n_chk = 0, n_fail = 0;
  logic [1:0] tb_err = 2'd0;
  logic       stall = 1'b0;

  function automatic logic [LB-1:0] init_line(input int i);
    logic [LB-1:0] l;
    for (int b = 0; b < NB; b++) l[b*8 +: 8] = 8'(i * 37 + b * 5 + 1);
    return l;
  endfunction

  function automatic logic [LB-1:0] overlay(input logic [LB-1:0] o, input logic [LB-1:0] n,
                                            input logic [NB-1:0] m);
    logic [LB-1:0] r;
    for (int b = 0; b < NB; b++) r[b*8 +: 8] = m[b] ? n[b*8 +: 8] : o[b*8 +: 8];
    return r;
  endfunction

  // memory responder and command log
  logic [LB-1:0] mem [0:7];
  logic [LB-1:0] exp_mem [0:7];
  int            cmd_total = 0;
  logic [1:0]    lg_op  [0:7];
  logic [AW-1:0] lg_addr[0:7];
  logic          lg_coh [0:7], lg_l2[0:7], lg_lane[0:7];
  logic [NB-1:0] lg_be  [0:7];
  logic [LB-1:0] lg_data[0:7];
  int            pend = 0;
  logic [2:0]    pidx = '0;

  always @(posedge clk) begin
    sb_rsp_valid <= 1'b0;
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) mem[i] <= init_line(i);
      pend <= 0;
    end else begin
      if (sb_cmd_valid && sb_cmd_ready) begin
        lg_op[cmd_total[2:0]]   <= sb_cmd_op;
        lg_addr[cmd_total[2:0]] <= sb_cmd_addr;
        lg_coh[cmd_total[2:0]]  <= sb_cmd_coherent;
        lg_l2[cmd_total[2:0]]   <= sb_cmd_l2alloc;
        lg_lane[cmd_total[2:0]] <= sb_cmd_lane;
        lg_be[cmd_total[2:0]]   <= sb_cmd_be;
        lg_data[cmd_total[2:0]] <= sb_cmd_data;
        cmd_total <= cmd_total + 1;
        if (sb_cmd_op == 2'd2)
          mem[sb_cmd_addr[7:5]] <= overlay(mem[sb_cmd_addr[7:5]], sb_cmd_data, sb_cmd_be);
        else begin
          pend <= 2;
          pidx <= sb_cmd_addr[7:5];
        end
      end
      if (pend != 0) begin
        pend <= pend - 1;
        if (pend == 1) begin
          sb_rsp_valid <= 1'b1;
          sb_rsp_data  <= mem[pidx];
          sb_rsp_err   <= tb_err;
        end
      end
    end
  end

  always @(negedge clk) sb_cmd_ready <= stall ? ~sb_cmd_ready : 1'b1;

  task automatic chk(input logic ok, input string tag, input logic [LB-1:0] act,
                     input logic [LB-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic          got;
  logic          g_err, g_nxa;
  logic [LB-1:0] g_data;
  int            base;

  task automatic do_req(input logic wr, input logic po, input logic [AW-1:0] a,
                        input logic [NB-1:0] m, input logic [LB-1:0] d, input logic iso);
    @(negedge clk);
    base = cmd_total;
    req_write = wr; req_posted = po; req_addr = a; req_be = m; req_data = d;
    req_isoc = iso; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    got = 1'b0; g_err = 1'b0; g_nxa = 1'b0; g_data = '0;
    for (int k = 0; k < 80; k++) begin
      if (lk_rsp_valid) begin
        got = 1'b1; g_err = lk_rsp_err; g_nxa = lk_rsp_nxa; g_data = lk_rsp_data;
      end
      if (req_ready) break;
      @(negedge clk);
    end
  endtask

  function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] a);
    return a & ~LANE_M & ~40'h1F;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) exp_mem[i] = init_line(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !sb_cmd_valid && !lk_rsp_valid, "R9 reset idle",
        {req_ready, sb_cmd_valid, lk_rsp_valid}, 3'b100);

    // attribute sweep with reads (R1 R2 R3 R10)
    for (int c = 0; c < 16; c++) begin
      logic be_sys, lb, iso, inmem;
      logic [AW-1:0] a;
      logic [NB-1:0] m;
      be_sys = c[0]; lb = c[1]; iso = c[2]; inmem = c[3];
      a = (inmem ? MEM_A : IO_A) + 40'(32 * (c % 8)) + 40'd3;
      if (lb) a = a | LANE_M;
      m = 32'h0000_FF0F;
      cfg_big_endian = be_sys;
      do_req(1'b0, 1'b0, a, m, '0, iso);
      chk(cmd_total - base == 1, "R3 one read cmd", LB'(cmd_total - base), 1);
      chk(lg_op[base[2:0]] == 2'd0, "R3 read op", LB'(lg_op[base[2:0]]), 0);
      chk(lg_lane[base[2:0]] == (be_sys & lb), "R1 lane policy",
          LB'(lg_lane[base[2:0]]), LB'(be_sys & lb));
      chk(lg_addr[base[2:0]] == exp_addr(a), "R1 cmd addr",
          LB'(lg_addr[base[2:0]]), LB'(exp_addr(a)));
      chk(lg_l2[base[2:0]] == iso, "R2 l2 alloc", LB'(lg_l2[base[2:0]]), LB'(iso));
      chk(lg_coh[base[2:0]] == inmem, "R3 coherent", LB'(lg_coh[base[2:0]]), LB'(inmem));
      chk(lg_be[base[2:0]] == (inmem ? '1 : m), "R3 byte enables",
          LB'(lg_be[base[2:0]]), LB'(inmem ? '1 : m));
      chk(got && !g_err && g_data == exp_mem[c % 8], "R10 read data", g_data,
          exp_mem[c % 8]);
    end
    cfg_big_endian = 1'b0;

    // partial coherent writes (R4 R8), with and without stall
    for (int p = 0; p < 8; p++) begin
      logic [NB-1:0] m;
      logic [LB-1:0] d, wexp;
      logic po, iso;
      int idx;
      case (p % 4)
        0: m = 32'h0000_0001;
        1: m = 32'h8000_0000;
        2: m = 32'h0F0F_F0F0;
        default: m = 32'h7FFF_FFFF;
      endcase
      if (p == 7) m = 32'h0;
      idx = p;
      po = p[0]; iso = p[1];
      stall = (p >= 4);
      tb_err = 2'(p);
      d = {8{32'hC0DE_0000 | 32'(p)}};
      wexp = overlay(exp_mem[idx], d, m);
      do_req(1'b1, po, MEM_A + 40'(32 * idx), m, d, iso);
      chk(cmd_total - base == 2, "R4 two cmds", LB'(cmd_total - base), 2);
      chk(lg_op[base[2:0]] == 2'd1 && lg_be[base[2:0]] == '1 && lg_coh[base[2:0]],
          "R4 read-exclusive", LB'(lg_op[base[2:0]]), 1);
      chk(lg_op[3'(base + 1)] == 2'd2 && lg_be[3'(base + 1)] == '1,
          "R4 full writeback", LB'(lg_op[3'(base + 1)]), 2);
      chk(lg_data[3'(base + 1)] == wexp, "R4 merged line", lg_data[3'(base + 1)], wexp);
      chk(lg_l2[base[2:0]] == iso && lg_l2[3'(base + 1)] == iso, "R2 l2 both cmds",
          LB'(lg_l2[3'(base + 1)]), LB'(iso));
      chk(got == !po, "R8 response presence", LB'(got), LB'(!po));
      chk(!g_err, "R8 write no error", LB'(g_err), 0);
      exp_mem[idx] = wexp;
    end
    stall = 1'b0;
    tb_err = 2'd0;

    // full coherent write (R5)
    begin
      logic [LB-1:0] d;
      d = {8{32'h1234_5678}};
      do_req(1'b1, 1'b0, MEM_A + 40'(32 * 2), '1, d, 1'b0);
      chk(cmd_total - base == 1, "R5 single cmd", LB'(cmd_total - base), 1);
      chk(lg_op[base[2:0]] == 2'd2 && lg_data[base[2:0]] == d, "R5 line write",
          lg_data[base[2:0]], d);
      exp_mem[2] = d;
    end

    // uncached partial write (R3)
    begin
      logic [LB-1:0] d;
      d = {8{32'hFEED_0000}};
      do_req(1'b1, 1'b1, IO_A + 40'(32 * 5), 32'h00FF_0000, d, 1'b0);
      chk(cmd_total - base == 1, "R3 uncached single write", LB'(cmd_total - base), 1);
      chk(lg_op[base[2:0]] == 2'd2 && !lg_coh[base[2:0]] &&
          lg_be[base[2:0]] == 32'h00FF_0000, "R3 uncached be",
          LB'(lg_be[base[2:0]]), LB'(32'h00FF_0000));
      chk(!got, "R8 posted no response", LB'(got), 0);
      exp_mem[5] = overlay(exp_mem[5], d, 32'h00FF_0000);
    end

    // error mapping sweep (R6 R7)
    for (int e = 0; e < 8; e++) begin
      logic md;
      logic xe;
      md = e[2];
      tb_err = e[1:0];
      cfg_mabort_mode = md;
      xe = (e[1:0] != 0) && (md || e[1:0] == 2'd3);
      do_req(1'b0, 1'b0, MEM_A + 40'(32 * (e % 8)), '1, '0, 1'b0);
      chk(got && g_err == xe && !g_nxa, md ? "R6 abort mapping" : "R7 default mapping",
          LB'({g_err, g_nxa}), LB'({xe, 1'b0}));
      if (!xe) chk(g_data == exp_mem[e % 8], "R7 data returned", g_data, exp_mem[e % 8]);
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule